// File: doc/BRIEF.md
# Branch-Capable Instruction Fetch Unit

This block is the front end of a single-cycle processor. It owns the 32-bit program counter, reads the instruction word at that address from an asynchronous-read instruction store, and works out the address of the next instruction on every clock. The counter has no load enable, so it takes a new value on every rising edge.

The next address is normally the current one plus four. When the control path selects the branch path and the arithmetic unit also reports a zero result, the next address is the sequential value plus the sign-extended 16-bit offset, scaled by four. The offset sits in bits 15:0 of the instruction being fetched. A branch that is selected while the zero flag is low falls through to the sequential address. The instruction store holds 256 words and is indexed by PC bits 9:2. The bench loads it before reset is released.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 at that edge. This is a synchronous, active-high reset.
- R2: With `br_sel` low, the PC advances by 4 at every rising edge, whatever `alu_zero` is. No enable is needed.
- R3: With `br_sel` and `alu_zero` both high, the next PC is PC + 4 + (sign-extended `instr[15:0]` shifted left by 2).
- R4: With `br_sel` high and `alu_zero` low, the branch is not taken and the next PC is PC + 4.
- R5: `instr` always equals the stored word at index PC[9:2]. It follows a PC change in the same cycle, with no clock edge in between. Addresses wrap modulo 1 KiB.
- R6: A negative offset (`instr[15]` = 1) gives a target below PC + 4. Offset 0xFFFF gives a target equal to the branch's own PC, and 0x8000 moves the PC back by 131068 bytes from the branch's own PC.
- R7: PC bits 1:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Selects the branch path for the next address |
| alu_zero | input | 1 | Zero flag from the arithmetic unit |
| instr | output | 32 | Instruction word at the current PC |
| pc | output | 32 | Current program counter |

## Verification
The run has four phases. In the first, `br_sel` is held low while `alu_zero` toggles, which shows that the zero flag alone never diverts the flow. In the second, `br_sel` is held high with `alu_zero` low, which separates a correct fall-through from a design that branches on the select alone. In the third, both are held high, so the target adder runs through offsets of 0, small positive values, -1, -3, -16 and the two extreme values. This tells sign extension apart from zero extension, and adding to PC + 4 apart from adding to the PC itself. A last phase mixes both inputs pseudo-randomly and applies a reset in mid-flow.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    parameter int PC_W   = 32;
    parameter int WORD_W = 32;
    parameter int OFF_W  = 16;
    parameter int IDX_W  = 8;

    typedef enum logic {
        NPC_SEQ    = 1'b0,
        NPC_BRANCH = 1'b1
    } npc_src_e;

    typedef struct packed {
        logic [WORD_W-OFF_W-1:0] upper;
        logic [OFF_W-1:0]        offset;
    } instr_view_t;

    function automatic logic [PC_W-1:0] scale_offset(input logic [OFF_W-1:0] off);
        return {{(PC_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction

endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
#(
    parameter int W   = PC_W,
    parameter int OW  = OFF_W
) (
    input  logic [W-1:0]  cur_pc,
    input  logic [OW-1:0] offset,
    input  logic          br_sel,
    input  logic          alu_zero,
    output logic [W-1:0]  nxt_pc
);
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] seq_pc;
    logic [W-1:0] disp;
    logic [W-1:0] tgt_pc;
    npc_src_e     src;

    assign seq_pc = cur_pc + STEP;
    assign disp   = {{(W-OW-2){offset[OW-1]}}, offset, 2'b00};
    assign tgt_pc = seq_pc + disp;
    assign src    = (br_sel && alu_zero) ? NPC_BRANCH : NPC_SEQ;

    always_comb begin
        unique case (src)
            NPC_BRANCH: nxt_pc = tgt_pc;
            default:    nxt_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
    import ifu_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = IDX_W
) (
    input  logic [AW-1:0] idx,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rom [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) rom[i] = '0;
    end

    assign rdata = rom[idx];
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
    import ifu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              br_sel,
    input  logic              alu_zero,
    output logic [WORD_W-1:0] instr,
    output logic [PC_W-1:0]   pc
);
    logic [PC_W-1:0] nxt_pc;
    instr_view_t     view;

    ifu_pc_reg #(.W(PC_W), .RESET_VAL('0)) u_pc (
        .clk (clk),
        .rst (rst),
        .d   (nxt_pc),
        .q   (pc)
    );

    ifu_imem #(.DW(WORD_W), .AW(IDX_W)) u_imem (
        .idx   (pc[IDX_W+1:2]),
        .rdata (instr)
    );

    assign view = instr_view_t'(instr);

    ifu_next_pc #(.W(PC_W), .OW(OFF_W)) u_npc (
        .cur_pc   (pc),
        .offset   (view.offset),
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .nxt_pc   (nxt_pc)
    );

    // R1: reset loads zero
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == '0);

    // R2: no branch select gives a plain step
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        !br_sel |=> pc == $past(pc) + PC_W'(4));

    // R4: selected but zero flag low falls through
    a_r4_fall_through: assert property (@(posedge clk) disable iff (rst)
        (br_sel && !alu_zero) |=> pc == $past(pc) + PC_W'(4));

    // R3: taken branch lands on step plus scaled offset
    a_r3_taken: assert property (@(posedge clk) disable iff (rst)
        (br_sel && alu_zero) |=>
            pc == $past(pc) + PC_W'(4) + scale_offset($past(instr[OFF_W-1:0])));

    // R7: word alignment
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

endmodule

// File: tb/ifu_fetch_unit_tb.sv
`timescale 1ns/1ps
module ifu_fetch_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;

    ifu_fetch_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .br_sel   (br_sel),
        .alu_zero (alu_zero),
        .instr    (instr),
        .pc       (pc)
    );

    always #4 clk = ~clk;

    logic [31:0] model_mem [256];
    logic [31:0] exp_pc = 32'd0;
    logic [15:0] lfsr = 16'hACE1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    function automatic logic [31:0] word_at(input int i);
        logic [15:0] imm;
        case (i % 8)
            0: imm = 16'hFFFD;
            1: imm = 16'h0003;
            2: imm = 16'h0000;
            3: imm = 16'hFFFF;
            4: imm = 16'h0010;
            5: imm = 16'h8000;
            6: imm = 16'h7FFF;
            default: imm = 16'hFFF0;
        endcase
        return {8'(i), 8'hC3, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h time=%0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle from a negedge; compare at the following negedge.
    task automatic cycle(input logic s, input logic z, input logic r);
        logic [31:0] cur;
        logic [31:0] nxt;
        logic [15:0] imm;
        string       tag;
        cur = model_mem[exp_pc[9:2]];
        imm = cur[15:0];
        br_sel   = s;
        alu_zero = z;
        rst      = r;
        if (r) begin
            nxt = 32'd0; tag = "R1";
        end else if (s && z) begin
            nxt = exp_pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
            tag = imm[15] ? "R6" : "R3";
        end else if (s) begin
            nxt = exp_pc + 32'd4; tag = "R4";
        end else begin
            nxt = exp_pc + 32'd4; tag = "R2";
        end
        @(negedge clk);
        exp_pc = nxt;
        check(tag, pc, exp_pc);
        check("R5", instr, model_mem[exp_pc[9:2]]);
        check("R7", {30'd0, pc[1:0]}, 32'd0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        #1;
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = word_at(i);
            u_dut.u_imem.rom[i] = model_mem[i];
        end
        @(negedge clk);
        // R1: reset state
        cycle(1'b0, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b1);
        // R2: sequential, zero flag toggling must not matter
        for (int k = 0; k < 60; k++) cycle(1'b0, k[0], 1'b0);
        // R4: branch selected but zero low
        for (int k = 0; k < 60; k++) cycle(1'b1, 1'b0, 1'b0);
        // R3 / R6: taken branches over every offset kind
        for (int k = 0; k < 80; k++) cycle(1'b1, 1'b1, 1'b0);
        // R1: reset in mid-flow
        cycle(1'b1, 1'b1, 1'b1);
        // mixed
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0], lfsr[3], (lfsr[11:4] == 8'h00));
        end
        summary();
    end

endmodule